// File: doc/BRIEF.md
# Memory Cycle and Instruction Timing Sequencer

This block turns a fast system clock into the timing frame of a core-style memory and counts whole memory cycles for each phase of an instruction. A one-hot ring of ten positions advances every second clock, so one pass of the ring is a 20-clock memory cycle. Within each cycle the block strobes a read/clear window early in the ring and a write window late in the ring. It enforces the rule that a write may only happen in a cycle that has already read or cleared the same location.

On a start request the block latches how many levels of indirection the instruction has and how many execute cycles it needs. At the next memory cycle boundary it then steps through the phases. Fetch lasts a fixed eight memory cycles. Each indirect level adds a four-cycle indirect step. The execute phase lasts the requested number of cycles. A one-clock done pulse marks the return to idle. Instruction decode and the data path sit outside and drive the request inputs.

Top module: `mem_cycle_seq`

## Requirements
- R1: `ring_pos` is one-hot. After reset it holds bit 0. It moves to the next higher bit every 2 clocks and wraps from bit 9 back to bit 0, so one memory cycle spans 20 clocks.
- R2: During and right after reset, `phase` is 0 (idle) and `rc_strobe`, `wr_strobe`, `wr_err` and `done` are all low.
- R3: The phase code is 0 idle, 1 fetch, 2 indirect and 3 execute. A `start` seen while idle latches `ind_levels` and `exec_cycles`. The instruction begins at the next memory cycle boundary and spends exactly 8 memory cycles (160 clocks) with phase 1.
- R4: Each latched indirect level adds one indirect step of 4 memory cycles (80 clocks) with phase 2, placed after fetch and before execute.
- R5: The execute phase (code 3) lasts the latched `exec_cycles` memory cycles, at 20 clocks each. A count of zero skips the execute phase entirely.
- R6: `done` is high for exactly one clock, on the clock where `phase` has returned to 0 after the last cycle of the instruction.
- R7: In a busy memory cycle whose `rc_req` was high on the last clock of the previous cycle, `rc_strobe` is high during ring positions 1 to 3 (6 clocks) and low elsewhere.
- R8: In a busy cycle with both requests sampled high, `wr_strobe` is high during ring positions 6 to 8 (6 clocks). It is never high in a cycle without a read/clear.
- R9: In a busy cycle with `wr_req` sampled high and `rc_req` low, no write strobe is issued. Instead `wr_err` pulses for one clock on entry to ring position 6.
- R10: `start` while an instruction is pending or running has no effect. Changes to `ind_levels` and `exec_cycles` after acceptance do not alter the phase lengths.
- R11: While `phase` is 0 no strobe and no error pulse is issued, whatever the request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| ind_levels | input | LVL_W (3) | Number of indirect levels |
| exec_cycles | input | CNT_W (8) | Execute length in memory cycles |
| rc_req | input | 1 | Read/clear wanted in the coming memory cycle |
| wr_req | input | 1 | Write wanted in the coming memory cycle |
| ring_pos | output | RING_LEN (10) | One-hot timing ring |
| phase | output | 2 | Current instruction phase code |
| rc_strobe | output | 1 | Read/clear strobe |
| wr_strobe | output | 1 | Write strobe |
| wr_err | output | 1 | Write requested without read/clear |
| done | output | 1 | Instruction finished pulse |

## Verification
The sequencing is driven with instructions whose indirect depth ranges from none to several and whose execute length ranges from zero to several cycles. The clocks spent in each phase separate a wrong fetch length from a wrong indirect step or a wrong execute count. The four combinations of read/clear and write requests separate the legal write, the read-only cycle, the refused write that must raise the error, and the quiet cycle. Further tests disturb the inputs during a run and hold requests while idle, to show that the latched parameters and the idle gating behave as required.

// File: rtl/mem_cycle_seq_pkg.sv
package mem_cycle_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_INDIR = 2'd2,
    PH_EXEC  = 2'd3
  } seq_phase_e;
endpackage

// File: rtl/seq_ring_timer.sv
module seq_ring_timer #(
  parameter int RING_LEN    = 10,
  parameter int CLK_PER_POS = 2
) (
  input  logic                clk,
  input  logic                rst,
  output logic [RING_LEN-1:0] ring_q,
  output logic [RING_LEN-1:0] nxt_ring,
  output logic                nxt_first,
  output logic                cycle_end
);
  localparam int SUB_W = (CLK_PER_POS > 1) ? $clog2(CLK_PER_POS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_POS - 1);

  logic [SUB_W-1:0] sub_q;
  logic             last;

  assign last      = (sub_q == SUB_LAST);
  assign nxt_first = last;
  assign cycle_end = last && ring_q[RING_LEN-1];
  assign nxt_ring  = last ? {ring_q[RING_LEN-2:0], ring_q[RING_LEN-1]} : ring_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q  <= '0;
      ring_q <= RING_LEN'(1);
    end else begin
      sub_q  <= last ? '0 : sub_q + SUB_W'(1);
      ring_q <= nxt_ring;
    end
  end

  p_ring_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot(ring_q));
  p_ring_hold_r1:   assert property (@(posedge clk) disable iff (rst) !last |=> $stable(ring_q));
  p_ring_wrap_r1:   assert property (@(posedge clk) disable iff (rst) cycle_end |=> ring_q[0]);
endmodule

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
  import mem_cycle_seq_pkg::*;
#(
  parameter int LVL_W      = 3,
  parameter int CNT_W      = 8,
  parameter int FETCH_CYC  = 8,
  parameter int INDIR_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LVL_W-1:0] ind_levels,
  input  logic [CNT_W-1:0] exec_cycles,
  input  logic             cycle_end,
  output seq_phase_e       phase_q,
  output seq_phase_e       nxt_phase,
  output logic             done_q
);
  localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(FETCH_CYC - 1);
  localparam logic [CNT_W-1:0] INDIR_LAST = CNT_W'(INDIR_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic [CNT_W-1:0] exe_q, exe_n;
  logic             pend_q, pend_n;
  logic             done_n;

  always_comb begin
    nxt_phase = phase_q;
    cnt_n     = cnt_q;
    lvl_n     = lvl_q;
    exe_n     = exe_q;
    pend_n    = pend_q;
    done_n    = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (!pend_q && start) begin
        pend_n = 1'b1;
        lvl_n  = ind_levels;
        exe_n  = exec_cycles;
      end
      if (pend_q && cycle_end) begin
        pend_n    = 1'b0;
        nxt_phase = PH_FETCH;
        cnt_n     = FETCH_LAST;
      end
    end else if (cycle_end) begin
      if (cnt_q != '0) begin
        cnt_n = cnt_q - CNT_W'(1);
      end else if (lvl_q != '0) begin
        nxt_phase = PH_INDIR;
        cnt_n     = INDIR_LAST;
        lvl_n     = lvl_q - LVL_W'(1);
      end else if (phase_q != PH_EXEC && exe_q != '0) begin
        nxt_phase = PH_EXEC;
        cnt_n     = exe_q - CNT_W'(1);
      end else begin
        nxt_phase = PH_IDLE;
        done_n    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      lvl_q   <= '0;
      exe_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= nxt_phase;
      cnt_q   <= cnt_n;
      lvl_q   <= lvl_n;
      exe_q   <= exe_n;
      pend_q  <= pend_n;
      done_q  <= done_n;
    end
  end

  p_done_pulse_r6:   assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
  p_done_idle_r6:    assert property (@(posedge clk) disable iff (rst) done_q |-> (phase_q == PH_IDLE));
  p_phase_frame_r3:  assert property (@(posedge clk) disable iff (rst) !cycle_end |=> $stable(phase_q));
  p_exec_last_r5:    assert property (@(posedge clk) disable iff (rst)
                       (phase_q == PH_EXEC) |=> (phase_q == PH_EXEC || phase_q == PH_IDLE));
endmodule

// File: rtl/seq_strobe_gen.sv
module seq_strobe_gen #(
  parameter int RING_LEN = 10,
  parameter int RC_LO    = 1,
  parameter int RC_HI    = 3,
  parameter int WR_LO    = 6,
  parameter int WR_HI    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RING_LEN-1:0] ring_q,
  input  logic [RING_LEN-1:0] nxt_ring,
  input  logic                nxt_first,
  input  logic                cycle_end,
  input  logic                active_nxt,
  input  logic                rc_req,
  input  logic                wr_req,
  output logic                rc_strobe_q,
  output logic                wr_strobe_q,
  output logic                wr_err_q
);
  function automatic logic in_win(input logic [RING_LEN-1:0] r, input int lo, input int hi);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < RING_LEN; i++) begin
      if (i >= lo && i <= hi) hit = hit | r[i];
    end
    return hit;
  endfunction

  logic cyc_rc_q, cyc_wr_q, cyc_rc_n, cyc_wr_n;
  logic rc_seen_q, rc_seen_n;
  logic rc_n, wr_n, err_n;

  always_comb begin
    cyc_rc_n  = cycle_end ? rc_req : cyc_rc_q;
    cyc_wr_n  = cycle_end ? wr_req : cyc_wr_q;
    rc_n      = active_nxt && cyc_rc_n && in_win(nxt_ring, RC_LO, RC_HI);
    rc_seen_n = nxt_ring[0] ? 1'b0 : (rc_seen_q | rc_n);
    wr_n      = active_nxt && cyc_wr_n && rc_seen_n && in_win(nxt_ring, WR_LO, WR_HI);
    err_n     = active_nxt && cyc_wr_n && !rc_seen_n && nxt_ring[WR_LO] && nxt_first;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_rc_q    <= 1'b0;
      cyc_wr_q    <= 1'b0;
      rc_seen_q   <= 1'b0;
      rc_strobe_q <= 1'b0;
      wr_strobe_q <= 1'b0;
      wr_err_q    <= 1'b0;
    end else begin
      cyc_rc_q    <= cyc_rc_n;
      cyc_wr_q    <= cyc_wr_n;
      rc_seen_q   <= rc_seen_n;
      rc_strobe_q <= rc_n;
      wr_strobe_q <= wr_n;
      wr_err_q    <= err_n;
    end
  end

  p_rc_window_r7:  assert property (@(posedge clk) disable iff (rst)
                     rc_strobe_q |-> in_win(ring_q, RC_LO, RC_HI));
  p_wr_window_r8:  assert property (@(posedge clk) disable iff (rst)
                     wr_strobe_q |-> in_win(ring_q, WR_LO, WR_HI));
  p_wr_after_rc_r8: assert property (@(posedge clk) disable iff (rst) wr_strobe_q |-> rc_seen_q);
  p_err_no_wr_r9:  assert property (@(posedge clk) disable iff (rst) wr_err_q |-> !wr_strobe_q);
  p_err_pulse_r9:  assert property (@(posedge clk) disable iff (rst) wr_err_q |=> !wr_err_q);
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq
  import mem_cycle_seq_pkg::*;
#(
  parameter int RING_LEN    = 10,
  parameter int CLK_PER_POS = 2,
  parameter int LVL_W       = 3,
  parameter int CNT_W       = 8,
  parameter int FETCH_CYC   = 8,
  parameter int INDIR_CYC   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LVL_W-1:0]    ind_levels,
  input  logic [CNT_W-1:0]    exec_cycles,
  input  logic                rc_req,
  input  logic                wr_req,
  output logic [RING_LEN-1:0] ring_pos,
  output logic [1:0]          phase,
  output logic                rc_strobe,
  output logic                wr_strobe,
  output logic                wr_err,
  output logic                done
);
  logic [RING_LEN-1:0] ring_q, nxt_ring;
  logic                nxt_first, cycle_end;
  seq_phase_e          phase_q, nxt_phase;

  seq_ring_timer #(.RING_LEN(RING_LEN), .CLK_PER_POS(CLK_PER_POS)) ring_i (
    .clk(clk), .rst(rst), .ring_q(ring_q), .nxt_ring(nxt_ring),
    .nxt_first(nxt_first), .cycle_end(cycle_end)
  );

  seq_phase_ctrl #(.LVL_W(LVL_W), .CNT_W(CNT_W), .FETCH_CYC(FETCH_CYC),
                   .INDIR_CYC(INDIR_CYC)) phase_i (
    .clk(clk), .rst(rst), .start(start), .ind_levels(ind_levels),
    .exec_cycles(exec_cycles), .cycle_end(cycle_end), .phase_q(phase_q),
    .nxt_phase(nxt_phase), .done_q(done)
  );

  seq_strobe_gen #(.RING_LEN(RING_LEN)) strobe_i (
    .clk(clk), .rst(rst), .ring_q(ring_q), .nxt_ring(nxt_ring),
    .nxt_first(nxt_first), .cycle_end(cycle_end),
    .active_nxt(nxt_phase != PH_IDLE), .rc_req(rc_req), .wr_req(wr_req),
    .rc_strobe_q(rc_strobe), .wr_strobe_q(wr_strobe), .wr_err_q(wr_err)
  );

  assign ring_pos = ring_q;
  assign phase    = phase_q;

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
                      (phase_q == PH_IDLE) |-> (!rc_strobe && !wr_strobe && !wr_err));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst) !(rc_strobe && wr_strobe));
endmodule

// File: tb/mem_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module mem_cycle_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] ind_levels = '0;
  logic [7:0] exec_cycles = '0;
  logic       rc_req = 1'b0, wr_req = 1'b0;
  logic [9:0] ring_pos;
  logic [1:0] phase;
  logic       rc_strobe, wr_strobe, wr_err, done;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  mem_cycle_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .ind_levels(ind_levels),
    .exec_cycles(exec_cycles), .rc_req(rc_req), .wr_req(wr_req),
    .ring_pos(ring_pos), .phase(phase), .rc_strobe(rc_strobe),
    .wr_strobe(wr_strobe), .wr_err(wr_err), .done(done)
  );

  // Vector layout: {levels[3], exec[8], rc, wr}
  localparam int NVEC = 7;
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 8'd1, 1'b1, 1'b1},
    {3'd0, 8'd5, 1'b1, 1'b0},
    {3'd2, 8'd3, 1'b1, 1'b1},
    {3'd1, 8'd2, 1'b0, 1'b1},
    {3'd0, 8'd0, 1'b1, 1'b1},
    {3'd3, 8'd0, 1'b0, 1'b0},
    {3'd1, 8'd4, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_instr(input int lvl, input int exe, input bit rc, input bit wr,
                           input bit disturb);
    int n_busy = 0, n_f = 0, n_i = 0, n_e = 0, n_rc = 0, n_wr = 0, n_err = 0;
    int n_done = 0, cyc;
    @(negedge clk);
    ind_levels = 3'(lvl); exec_cycles = 8'(exe); rc_req = rc; wr_req = wr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (disturb && k == 100) begin start = 1'b1; ind_levels = 3'd7; exec_cycles = 8'd9; end
      if (disturb && k == 101) start = 1'b0;
      if (phase != 2'd0) n_busy++;
      if (phase == 2'd1) n_f++;
      if (phase == 2'd2) n_i++;
      if (phase == 2'd3) n_e++;
      if (rc_strobe) n_rc++;
      if (wr_strobe) n_wr++;
      if (wr_err) n_err++;
      if (done) begin n_done++; chk("R6 idle at done", phase, 0); break; end
      @(negedge clk);
    end
    cyc = 8 + 4 * lvl + exe;
    chk(disturb ? "R10 busy clocks" : "R3 busy clocks", n_busy, 20 * cyc);
    chk("R3 fetch clocks", n_f, 160);
    chk("R4 indirect clocks", n_i, 80 * lvl);
    chk("R5 execute clocks", n_e, 20 * exe);
    chk("R7 rc strobe clocks", n_rc, rc ? 6 * cyc : 0);
    chk("R8 wr strobe clocks", n_wr, (rc && wr) ? 6 * cyc : 0);
    chk("R9 error pulses", n_err, (wr && !rc) ? cyc : 0);
    chk("R6 done seen", n_done, 1);
    @(negedge clk);
    chk("R6 done one clock", done, 0);
    chk("R6 idle after", phase, 0);
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 phase", phase, 0);
    chk("R2 rc_strobe", rc_strobe, 0);
    chk("R2 wr_strobe", wr_strobe, 0);
    chk("R2 wr_err", wr_err, 0);
    chk("R2 done", done, 0);
    chk("R1 reset ring", ring_pos, 10'd1);
    rst = 1'b0;
    // R1: ring holds 2 clocks per position and wraps
    for (int n = 0; n < 46; n++) begin
      chk("R1 ring position", ring_pos, 10'd1 << ((n / 2) % 10));
      @(negedge clk);
    end
    // Main table
    for (int v = 0; v < NVEC; v++) begin
      run_instr(int'(VEC[v][12:10]), int'(VEC[v][9:2]), VEC[v][1], VEC[v][0], 1'b0);
    end
    // R10: start and parameter changes during a run are ignored
    run_instr(1, 2, 1'b1, 1'b1, 1'b1);
    // R11: requests while idle produce nothing
    begin
      int q = 0;
      rc_req = 1'b1; wr_req = 1'b1;
      for (int n = 0; n < 60; n++) begin
        @(negedge clk);
        if (rc_strobe || wr_strobe || wr_err || phase != 2'd0) q++;
      end
      chk("R11 idle quiet", q, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule